// File: doc/BRIEF.md
# APB Requester Transfer Engine

This block is the requester side of an APB3 link to a single completer. A local client hands it one read or write command at a time over a valid/acknowledge pair. The engine then runs the bus through its idle, setup and access phases, holding the access phase open for as long as the completer keeps PREADY low. When the access completes, it reports the result to the client with a one-cycle done pulse, the captured read data and the error flag.

Wait states only lengthen the access phase. They never restart the transfer, and every signal that defines the access stays frozen until the single completion cycle. If the client already has the next command waiting when a transfer completes, that command's setup cycle follows immediately with no idle cycle in between. The two accesses are adjacent but never share a cycle.

The address width, the data width and the idle-parking variant are parameters. With parking enabled, the address, write data and direction outputs read zero whenever the bus is unselected.

Top module: `pbus_requester`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises with no command pending, psel, penable and rsp_done are 0.
- R2: req_ack is high only in a cycle where the bus is unselected (psel = 0) or where the current access completes (psel = penable = pready = 1). A command is taken at the clock edge that ends the cycle in which req_valid and req_ack are both high.
- R3: Each transfer starts with exactly one setup cycle (psel = 1, penable = 0), in which paddr, pwrite and pwdata carry the accepted command. The next cycle has penable = 1.
- R4: During access (psel = penable = 1), a cycle with pready = 0 is followed by another access cycle. The engine never falls back to setup and never leaves the bus before completion.
- R5: paddr, pwrite, pwdata and psel keep the values they had in the setup cycle through every cycle of the access, up to and including the completion cycle.
- R6: The access completes on the first access cycle with pready = 1. A transfer whose completer inserts N wait cycles therefore occupies 1 setup cycle plus N+1 access cycles, and the engine never enters access without a fresh setup.
- R7: rsp_done is high for exactly one cycle, the cycle after the completion cycle. In that cycle rsp_rdata holds the value prdata had on the completion cycle for a read, and 0 for a write.
- R8: rsp_err equals the value pslverr had on the completion cycle. pslverr values during wait cycles, and pready being low, have no effect on it.
- R9: If req_valid is high on a completion cycle, the next cycle is the setup cycle of that command. Otherwise the next cycle has psel = 0.
- R10: With PARK_ZERO = 1 (the default), paddr, pwdata and pwrite are all 0 in every cycle where psel = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Client has a command pending |
| req_write | input | 1 | Command direction, 1 = write |
| req_addr | input | ADDR_W | Command address |
| req_wdata | input | DATA_W | Command write data |
| req_ack | output | 1 | Command is taken at this clock edge |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_rdata | output | DATA_W | Read data of the finished transfer (0 for writes) |
| rsp_err | output | 1 | Completer error of the finished transfer |
| psel | output | 1 | Completer select |
| penable | output | 1 | Access phase enable |
| paddr | output | ADDR_W | Bus address |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| pready | input | 1 | Completer ready, low inserts a wait cycle |
| prdata | input | DATA_W | Completer read data |
| pslverr | input | 1 | Completer error indication |

## Verification
A command acknowledged at a clock edge produces its setup cycle in the very next cycle and its first access cycle one cycle after that. Completion lands exactly N+1 access cycles later, and rsp_done with its data follows one cycle after completion. The bench's completer model drives pready, prdata and pslverr in the middle of each access cycle from a per-transfer wait count. It counts access cycles itself, so it knows which cycle completes the access, and it arms the result check for the following cycle only; a done pulse in any other cycle is a failure. During wait cycles the model drives deliberately wrong prdata and a high pslverr, so sampling either one early shows up as a mismatch. The next-cycle check after each completion compares against req_valid as the design saw it at that clock edge.

// File: rtl/pbus_req_pkg.sv
package pbus_req_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACCESS = 2'd2
   } pbus_phase_e;

   localparam int unsigned PBUS_MAX_W = 1024;

endpackage

// File: rtl/pbus_phase_fsm.sv
module pbus_phase_fsm
   import pbus_req_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        pready,
   output pbus_phase_e phase,
   output logic        req_ack,
   output logic        complete
);

   pbus_phase_e phase_q;
   pbus_phase_e phase_d;

   // completion: in ACCESS psel and penable are both high by construction
   assign complete = (phase_q == PH_ACCESS) && pready;
   assign req_ack  = req_valid && ((phase_q == PH_IDLE) || complete);

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (req_valid) phase_d = PH_SETUP;
         PH_SETUP:  phase_d = PH_ACCESS;
         PH_ACCESS: begin
            if (pready) phase_d = req_valid ? PH_SETUP : PH_IDLE;
         end
         default:   phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   assign phase = phase_q;

endmodule

// File: rtl/pbus_cmd_hold.sv
module pbus_cmd_hold #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          PARK_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              drive_en,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              held_write,
   output logic              paddr_vld_write,
   output logic [ADDR_W-1:0] paddr,
   output logic [DATA_W-1:0] pwdata
);

   logic              write_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;

   // registers change only on acceptance, so they stay frozen for the whole access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         write_q <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (load) begin
         write_q <= cmd_write;
         addr_q  <= cmd_addr;
         wdata_q <= cmd_wdata;
      end
   end

   assign held_write = write_q;

   generate
      if (PARK_ZERO) begin : g_park
         assign paddr_vld_write = drive_en & write_q;
         assign paddr           = drive_en ? addr_q  : '0;
         assign pwdata          = drive_en ? wdata_q : '0;
      end else begin : g_keep
         assign paddr_vld_write = write_q;
         assign paddr           = addr_q;
         assign pwdata          = wdata_q;
      end
   endgenerate

endmodule

// File: rtl/pbus_resp_capture.sv
module pbus_resp_capture #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              complete,
   input  logic              is_write,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pslverr,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done  <= 1'b0;
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         done <= complete;
         if (complete) begin
            rdata <= is_write ? '0 : prdata;
            err   <= pslverr;
         end
      end
   end

endmodule

// File: rtl/pbus_requester.sv
module pbus_requester
   import pbus_req_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          PARK_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ack,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              psel,
   output logic              penable,
   output logic [ADDR_W-1:0] paddr,
   output logic              pwrite,
   output logic [DATA_W-1:0] pwdata,
   input  logic              pready,
   input  logic [DATA_W-1:0] prdata,
   input  logic              pslverr
);

   generate
      if (ADDR_W < 1 || ADDR_W > PBUS_MAX_W) begin : g_bad_addr_w
         $error("pbus_requester: ADDR_W out of range");
      end
      if (DATA_W < 1 || DATA_W > PBUS_MAX_W) begin : g_bad_data_w
         $error("pbus_requester: DATA_W out of range");
      end
   endgenerate

   pbus_phase_e phase;
   logic        complete;
   logic        held_write;
   logic        bus_active;

   pbus_phase_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .pready    (pready),
      .phase     (phase),
      .req_ack   (req_ack),
      .complete  (complete)
   );

   assign bus_active = (phase != PH_IDLE);
   assign psel       = bus_active;
   assign penable    = (phase == PH_ACCESS);

   pbus_cmd_hold #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .PARK_ZERO (PARK_ZERO)
   ) u_hold (
      .clk             (clk),
      .rst_n           (rst_n),
      .load            (req_ack),
      .drive_en        (bus_active),
      .cmd_write       (req_write),
      .cmd_addr        (req_addr),
      .cmd_wdata       (req_wdata),
      .held_write      (held_write),
      .paddr_vld_write (pwrite),
      .paddr           (paddr),
      .pwdata          (pwdata)
   );

   pbus_resp_capture #(
      .DATA_W (DATA_W)
   ) u_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .complete (complete),
      .is_write (held_write),
      .prdata   (prdata),
      .pslverr  (pslverr),
      .done     (rsp_done),
      .rdata    (rsp_rdata),
      .err      (rsp_err)
   );

endmodule

// File: rtl/pbus_requester_chk.sv
module pbus_requester_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter bit          PARK_ZERO = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ack,
   input logic              rsp_done,
   input logic              psel,
   input logic              penable,
   input logic [ADDR_W-1:0] paddr,
   input logic              pwrite,
   input logic [DATA_W-1:0] pwdata,
   input logic              pready
);

   // R2: acknowledge only when unselected or completing
   p_ack_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> (!psel || (penable && pready)));

   // R3: a setup cycle is always followed by an access cycle
   p_setup_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !penable) |=> (psel && penable));

   // R3: penable never appears without psel
   p_en_needs_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
      penable |-> psel);

   // R4: a wait cycle keeps the access open
   p_wait_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && !pready) |=> (psel && penable));

   // R5: access-defining outputs frozen from setup on through every wait
   p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !(penable && pready)) |=>
         ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

   // R6: access is entered only from setup or from another wait cycle
   p_access_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable) |-> $past(psel && !(penable && pready)));

   // R7: completion yields a done pulse in the next cycle, and only then
   p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready) |=> rsp_done);
   p_done_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |-> $past(psel && penable && pready));

   // R9: pending command at completion goes straight to setup
   p_b2b_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pready && req_valid) |=> (psel && !penable));

   generate
      if (PARK_ZERO) begin : g_park_chk
         // R10: parked outputs are zero while unselected
         p_park_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !psel |-> (paddr == '0 && pwdata == '0 && !pwrite));
      end
   endgenerate

endmodule

bind pbus_requester pbus_requester_chk #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .PARK_ZERO (PARK_ZERO)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ack   (req_ack),
   .rsp_done  (rsp_done),
   .psel      (psel),
   .penable   (penable),
   .paddr     (paddr),
   .pwrite    (pwrite),
   .pwdata    (pwdata),
   .pready    (pready)
);

// File: tb/sim_pbus_requester.sv
`timescale 1ns/1ps
module sim_pbus_requester;

   localparam int AW = 32;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ack;
   logic          rsp_done;
   logic [DW-1:0] rsp_rdata;
   logic          rsp_err;
   logic          psel, penable, pwrite;
   logic [AW-1:0] paddr;
   logic [DW-1:0] pwdata;
   logic          pready = 1'b0;
   logic [DW-1:0] prdata = '0;
   logic          pslverr = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   pbus_requester #(.ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
      .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .psel(psel), .penable(penable), .paddr(paddr), .pwrite(pwrite),
      .pwdata(pwdata), .pready(pready), .prdata(prdata), .pslverr(pslverr)
   );

   typedef struct {
      logic          wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [DW-1:0] rd;
      int            waits;
      logic          e;
   } xfer_t;

   typedef struct {
      logic [DW-1:0] rd;
      logic          e;
   } result_t;

   xfer_t   sub_q[$];
   result_t exp_q[$];

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         bad++;
         total++;
         $display("FAIL watchdog act=%0d exp=0", cyc);
         finish_run();
      end
   end

   // req_valid as the design saw it at the last edge
   logic vld_q = 1'b0;
   always @(posedge clk) vld_q = req_valid;

   // completer model + result monitor
   bit            in_acc   = 0;
   bit            done_due = 0;
   bit            nxt_chk  = 0;
   int            j        = 0;
   logic [AW-1:0] s_a;
   logic [DW-1:0] s_d;
   logic          s_w;

   always @(negedge clk) begin
      if (rst_n) begin
         xfer_t   cur;
         result_t r;
         if (done_due) begin
            chk(rsp_done == 1'b1, "R7", "done pulse missing", 64'(rsp_done), 64'd1);
            if (exp_q.size() > 0) begin
               r = exp_q.pop_front();
               chk(rsp_rdata == r.rd, "R7", "rdata", 64'(rsp_rdata), 64'(r.rd));
               chk(rsp_err == r.e, "R8", "err", 64'(rsp_err), 64'(r.e));
            end
         end else if (rsp_done) begin
            chk(1'b0, "R7", "done outside its cycle", 64'd1, 64'd0);
         end
         done_due = 0;
         if (nxt_chk) begin
            if (vld_q) chk(psel && !penable, "R9", "setup right after completion",
                           64'({psel, penable}), 64'd2);
            else       chk(!psel, "R9", "idle after completion", 64'(psel), 64'd0);
         end
         nxt_chk = 0;
         pready  = 1'b0;
         prdata  = 32'hDEAD_BEEF;
         pslverr = 1'b1;
         if (!psel) begin
            if (in_acc) chk(1'b0, "R4", "bus dropped mid-access", 64'd0, 64'd1);
            in_acc = 0;
            if (penable) chk(1'b0, "R3", "penable without psel", 64'd1, 64'd0);
            if (paddr != '0 || pwdata != '0 || pwrite)
               chk(1'b0, "R10", "idle outputs not parked",
                   64'({paddr[15:0], pwdata[15:0], 31'd0, pwrite}), 64'd0);
         end else if (!penable) begin
            if (in_acc) chk(1'b0, "R4", "setup re-entered mid-access", 64'd1, 64'd0);
            if (sub_q.size() == 0) begin
               chk(1'b0, "R3", "setup with no command", 64'd1, 64'd0);
            end else begin
               cur = sub_q[0];
               chk(paddr == cur.a, "R3", "setup paddr", 64'(paddr), 64'(cur.a));
               chk(pwrite == cur.wr, "R3", "setup pwrite", 64'(pwrite), 64'(cur.wr));
               chk(pwdata == cur.d, "R3", "setup pwdata", 64'(pwdata), 64'(cur.d));
               s_a = paddr; s_d = pwdata; s_w = pwrite;
               in_acc = 1;
               j = 0;
            end
         end else begin
            if (!in_acc || sub_q.size() == 0) begin
               chk(1'b0, "R6", "access without setup", 64'd1, 64'd0);
            end else begin
               cur = sub_q[0];
               if (paddr != s_a || pwdata != s_d || pwrite != s_w)
                  chk(1'b0, "R5", "access signals moved", 64'(paddr), 64'(s_a));
               if (j == cur.waits) begin
                  pready  = 1'b1;
                  prdata  = cur.rd;
                  pslverr = cur.e;
                  chk(j + 1 == cur.waits + 1, "R6", "access length", 64'(j + 1),
                      64'(cur.waits + 1));
                  done_due = 1;
                  nxt_chk  = 1;
                  in_acc   = 0;
                  void'(sub_q.pop_front());
               end else begin
                  prdata = ~cur.rd;
               end
               j++;
            end
         end
      end
   end

   // driver: entered and left at negedge + 2
   task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [DW-1:0] rd, input int waits, input logic e);
      xfer_t   x;
      result_t r;
      bit      got;
      x.wr = wr; x.a = a; x.d = d; x.rd = rd; x.waits = waits; x.e = e;
      r.rd = wr ? '0 : rd;
      r.e  = e;
      sub_q.push_back(x);
      exp_q.push_back(r);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      do begin
         #5;
         got = req_ack;
         if (got) chk(!psel || (penable && pready), "R2", "ack outside window",
                      64'({psel, penable, pready}), 64'd7);
         @(negedge clk);
         #2;
      end while (!got);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      #2;
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!psel && !penable && !rsp_done, "R1", "outputs in reset",
          64'({psel, penable, rsp_done}), 64'd0);
      #2;
      rst_n = 1'b1;
      idle(2);
      chk(!psel && !penable && !rsp_done, "R1", "outputs after reset",
          64'({psel, penable, rsp_done}), 64'd0);

      // R3 R7: zero-wait write and read
      issue(1'b1, 32'h0000_0010, 32'h1234_5678, 32'h0, 0, 1'b0);
      idle(4);
      issue(1'b0, 32'h0000_0014, 32'h0, 32'hCAFE_F00D, 0, 1'b0);
      idle(4);
      // R4 R6 R8: stretched read reporting an error
      issue(1'b0, 32'h0000_0100, 32'h0, 32'h0BAD_0BAD, 3, 1'b1);
      idle(7);
      // R8: pslverr high through waits, low at completion
      issue(1'b1, 32'h0000_0200, 32'hA5A5_5A5A, 32'h0, 5, 1'b0);
      idle(9);
      // R9: back-to-back chain
      issue(1'b0, 32'h0000_0300, 32'h0, 32'h1111_2222, 1, 1'b0);
      issue(1'b1, 32'h0000_0304, 32'h3333_4444, 32'h0, 0, 1'b1);
      issue(1'b0, 32'h0000_0308, 32'h0, 32'h5555_6666, 2, 1'b0);
      idle(6);
      // mixed sweep of directions, wait counts and gaps
      for (int i = 0; i < 24; i++) begin
         issue(logic'(i % 2), 32'h0000_1000 + 32'(i * 4),
               32'hA500_0000 ^ 32'(i * 32'h0101_0101),
               32'h5A00_0000 ^ 32'(i * 32'h0011_0011),
               i % 5, logic'(i % 7 == 3));
         if (i % 6 == 5) idle(i % 4);
      end
      while (sub_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
      idle(4);
      chk(!psel && !rsp_done, "R9", "bus idle at end", 64'({psel, rsp_done}), 64'd0);
      finish_run();
   end

endmodule